// File: doc/BRIEF.md
# Third-Order Sinc Bitstream Decimator

This block turns the one-bit output of a delta-sigma modulator into signed 16-bit samples at a lower rate. It uses a third-order sinc (cascaded integrator-comb) structure. Three integrators run on every accepted modulator bit. After every OSR accepted bits, the value of the last integrator passes through three differencing stages, and the result is written to the output word. The response is `((1 - z^-OSR) / (1 - z^-1))^3`. It has its first notch at the output word rate, and one output word is produced for every OSR modulator bits.

The decimation ratio is chosen at run time from the powers of two between 16 and 256. Each bit counts as +1 when high and -1 when low. The differencing result is rescaled so that full scale fills the signed 16-bit word at every ratio, so a downstream consumer never needs to know the ratio to read the value. A settled flag reports when the output no longer carries any part of the start-up transient. This happens at the third output word after a reset or a ratio change.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is asserted, and right after it, `out_word` is 0 and both `out_vld` and `settled` are low.
- R2: For a steady bit pattern whose fraction of ones is p, and whose period divides OSR, each settled output word equals 32768·(2p−1), read as signed 16-bit two's complement. The value is the same at every OSR.
- R3: `out_vld` is high for exactly one clock. It rises one clock after the rising edge that accepts every OSR-th bit, counted from a reset or a ratio change.
- R4: `osr_sel` value s in 0..4 selects OSR = 2^(4+s), which is 16, 32, 64, 128 or 256. Values 5, 6 and 7 select 256.
- R5: `settled` stays low for the first two output words after a reset or ratio change. It rises in the same clock as the third `out_vld` and then stays high.
- R6: A change of the decoded ratio clears the integrators, the differencing delays, the bit counter and `settled`. The bit offered in that clock is discarded.
- R7: Clocks with `bit_vld` low change neither the filter state nor the bit count, whatever `bit_in` holds.
- R8: `out_word` holds its value in every clock in which `out_vld` is low.
- R9: An all-ones input settles to 32767 (the clamped limit) and an all-zeros input settles to −32768, at every OSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a modulator bit this clock |
| bit_in | input | 1 | Modulator bit: 1 counts as +1, 0 counts as −1 |
| osr_sel | input | 3 | Decimation ratio select; see R4 |
| out_word | output | 16 | Signed decimated sample |
| out_vld | output | 1 | One-clock strobe marking a new `out_word` |
| settled | output | 1 | High once outputs are free of start-up transient |

## Verification
The bench builds the block with its default parameters: three stages, ratios from 16 to 256 and a 16-bit word. At these values every ratio and every ones-density of a 16-bit repeating pattern, all seventeen of them, can be swept in full. The pattern period divides every ratio, so the settled word is known exactly in advance: 2048·(2d−16) for d ones, clamped at the top. The same sweep therefore covers the full-scale limits, the ratio-independent scaling, the output spacing in accepted bits and the warm-up sequence of the settled flag. Separate runs insert idle clocks that carry inverted bits, and apply an out-of-range select code.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Warm-up progress of the filter after a reset or ratio change.
    typedef enum logic [1:0] {
        WARM_EMPTY,   // no output word produced yet
        WARM_ONE,     // one transient word produced
        WARM_TWO,     // two transient words produced
        WARM_LOCKED   // window fully filled by post-clear bits
    } warm_t;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int MIN_LOG = 4,
    parameter int MAX_LOG = 8,
    parameter int SEL_W   = 3,
    parameter int LOG_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic [SEL_W-1:0] osr_sel,
    output logic             clear,
    output logic             take,
    output logic [LOG_W-1:0] osr_log,
    output logic             settled
);

    localparam int SEL_TOP = MAX_LOG - MIN_LOG;

    logic [LOG_W-1:0]   req_log;
    logic [LOG_W-1:0]   log_q;
    logic [MAX_LOG-1:0] cnt_q;
    logic [MAX_LOG:0]   span;
    logic [MAX_LOG-1:0] limit;
    logic               last;
    warm_t              state_q;
    warm_t              state_d;

    // Ratio decode: out-of-range codes fall back to the largest ratio.
    always_comb begin
        if (osr_sel > SEL_W'(SEL_TOP)) begin
            req_log = LOG_W'(MAX_LOG);
        end else begin
            req_log = LOG_W'(MIN_LOG) + LOG_W'(osr_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q <= LOG_W'(MAX_LOG);
        end else begin
            log_q <= req_log;
        end
    end

    assign clear   = (req_log != log_q);
    assign osr_log = log_q;

    // Bit counter within one decimation window.
    always_comb begin
        span  = (MAX_LOG + 1)'(1) << log_q;
        limit = MAX_LOG'(span - 1'b1);
    end

    assign last = (cnt_q == limit);
    assign take = bit_vld & ~clear & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bit_vld) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // Warm-up state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WARM_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: a clear restarts; each output word advances one step.
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = WARM_EMPTY;
        end else if (take) begin
            unique case (state_q)
                WARM_EMPTY:  state_d = WARM_ONE;
                WARM_ONE:    state_d = WARM_TWO;
                WARM_TWO:    state_d = WARM_LOCKED;
                WARM_LOCKED: state_d = WARM_LOCKED;
                default:     state_d = WARM_EMPTY;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            WARM_LOCKED: settled = 1'b1;
            WARM_EMPTY,
            WARM_ONE,
            WARM_TWO:    settled = 1'b0;
            default:     settled = 1'b0;
        endcase
    end

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int STAGES = 3,
    parameter int ACC_W  = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum_next
);

    logic [ACC_W-1:0] sample;

    // +1 for a high bit, -1 (all ones) for a low bit.
    assign sample = bit_in ? ACC_W'(1) : '1;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] acc_n;
        logic [ACC_W-1:0] feed;

        if (s == 0) begin : g_head
            assign feed = sample;
        end else begin : g_tail
            assign feed = g_stage[s-1].acc_n;
        end

        // Modular sum: wrap-around cancels in the differencing stages.
        assign acc_n = acc_q + feed;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (clear) begin
                acc_q <= '0;
            end else if (bit_vld) begin
                acc_q <= acc_n;
            end
        end
    end

    assign sum_next = g_stage[STAGES-1].acc_n;

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int STAGES  = 3,
    parameter int MAX_LOG = 8,
    parameter int ACC_W   = 26,
    parameter int OUT_W   = 16,
    parameter int LOG_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [ACC_W-1:0] samp,
    input  logic [LOG_W-1:0] osr_log,
    output logic [OUT_W-1:0] out_word,
    output logic             out_vld
);

    localparam int DROP = STAGES * MAX_LOG - (OUT_W - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    for (genvar s = 0; s < STAGES; s++) begin : g_diff
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] diff_in;
        logic [ACC_W-1:0] diff_out;

        if (s == 0) begin : g_head
            assign diff_in = samp;
        end else begin : g_tail
            assign diff_in = g_diff[s-1].diff_out;
        end

        assign diff_out = diff_in - dly_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_q <= '0;
            end else if (clear) begin
                dly_q <= '0;
            end else if (take) begin
                dly_q <= diff_in;
            end
        end
    end

    logic [ACC_W-1:0]        res;
    int                      shl;
    logic signed [ACC_W-1:0] norm;
    logic signed [ACC_W-1:0] scaled;
    logic [OUT_W-1:0]        word_d;

    assign res = g_diff[STAGES-1].diff_out;

    // Bring every ratio to the gain of the largest, then drop to OUT_W.
    always_comb begin
        shl    = STAGES * (MAX_LOG - int'(osr_log));
        norm   = $signed(res) <<< shl;
        scaled = norm >>> DROP;
        if (scaled > SAT_HI) begin
            word_d = SAT_HI[OUT_W-1:0];
        end else if (scaled < SAT_LO) begin
            word_d = SAT_LO[OUT_W-1:0];
        end else begin
            word_d = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= take;
            if (take) begin
                out_word <= word_d;
            end
        end
    end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int STAGES  = 3,
    parameter int MIN_LOG = 4,
    parameter int MAX_LOG = 8,
    parameter int OUT_W   = 16,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] osr_sel,
    output logic [OUT_W-1:0] out_word,
    output logic             out_vld,
    output logic             settled
);

    localparam int ACC_W = STAGES * MAX_LOG + 2;
    localparam int LOG_W = $clog2(MAX_LOG + 1);

    logic             clear;
    logic             take;
    logic [LOG_W-1:0] osr_log;
    logic [ACC_W-1:0] sum_next;

    sinc3_ctrl #(
        .MIN_LOG (MIN_LOG),
        .MAX_LOG (MAX_LOG),
        .SEL_W   (SEL_W),
        .LOG_W   (LOG_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .osr_sel (osr_sel),
        .clear   (clear),
        .take    (take),
        .osr_log (osr_log),
        .settled (settled)
    );

    sinc3_integ #(
        .STAGES (STAGES),
        .ACC_W  (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .sum_next (sum_next)
    );

    sinc3_comb #(
        .STAGES  (STAGES),
        .MAX_LOG (MAX_LOG),
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W),
        .LOG_W   (LOG_W)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .take     (take),
        .samp     (sum_next),
        .osr_log  (osr_log),
        .out_word (out_word),
        .out_vld  (out_vld)
    );

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
    parameter int OUT_W = 16,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_vld,
    input logic [SEL_W-1:0] osr_sel,
    input logic [OUT_W-1:0] out_word,
    input logic             out_vld,
    input logic             settled
);

    // R3: the strobe never lasts two clocks.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    // R3, R7: a strobe always follows a clock that offered a bit.
    p_strobe_after_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(bit_vld));

    // R5: settled rises only together with a new word.
    p_settled_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> out_vld);

    // R5: settled stays high while the select input is unchanged.
    p_settled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $stable(osr_sel)) |=> settled);

    // R8: the word changes only under the strobe.
    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_word));

endmodule

bind sinc3_decim sinc3_decim_chk #(
    .OUT_W (OUT_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .osr_sel  (osr_sel),
    .out_word (out_word),
    .out_vld  (out_vld),
    .settled  (settled)
);

// File: tb/sinc3_decim_test.sv
`timescale 1ns/1ps
module sinc3_decim_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [2:0]  osr_sel = 3'd0;
    logic [15:0] out_word;
    logic        out_vld;
    logic        settled;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sinc3_decim uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .osr_sel  (osr_sel),
        .out_word (out_word),
        .out_vld  (out_vld),
        .settled  (settled)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Settled word for d ones in every 16 bits, per R2 and R9.
    function automatic int expect_word(input int d);
        int e;
        e = 2048 * (2 * d - 16);
        if (e > 32767) e = 32767;
        return e;
    endfunction

    task automatic run_cfg(input int sel, input int d, input bit gappy);
        int    osr;
        int    nout;
        int    idx;
        int    taken;
        int    mark;
        int    guard;
        bit    prev_v;
        bit    prev_o;
        logic [15:0] last_w;
        string vlabel;
        osr    = (sel > 4) ? 256 : (16 << sel);
        vlabel = gappy ? "R7" : ((sel > 4) ? "R4" : ((d == 0 || d == 16) ? "R9" : "R2"));
        nout = 0; idx = 0; taken = 0; mark = 0; guard = 0;
        prev_v = 1'b0; prev_o = 1'b0;
        bit_vld = 1'b0;
        osr_sel = sel[2:0];
        repeat (2) @(negedge clk);
        chk(settled == 1'b0, "R6 settled cleared by ratio change", int'(settled), 0);
        last_w = out_word;
        while (nout < 4 && guard < 20 * osr + 100) begin
            @(negedge clk);
            guard++;
            if (prev_v) taken++;
            if (prev_o) chk(out_vld == 1'b0, "R3 strobe width", int'(out_vld), 0);
            if (out_vld) begin
                nout++;
                chk(taken - mark == osr, "R4 bits per word", taken - mark, osr);
                mark = taken;
                if (nout <= 2) begin
                    chk(settled == 1'b0, "R5 settled low in warm-up", int'(settled), 0);
                end else begin
                    chk(settled == 1'b1, "R5 settled high", int'(settled), 1);
                    chk(int'($signed(out_word)) == expect_word(d), vlabel,
                        int'($signed(out_word)), expect_word(d));
                end
                last_w = out_word;
            end else begin
                chk(out_word == last_w, "R8 word hold", int'(out_word), int'(last_w));
            end
            prev_o = out_vld;
            if (gappy && (guard % 3 == 0)) begin
                bit_vld = 1'b0;
                bit_in  = !((idx % 16) < d);
            end else begin
                bit_vld = 1'b1;
                bit_in  = ((idx % 16) < d);
                idx++;
            end
            prev_v = bit_vld;
        end
        chk(nout == 4, "R3 word count", nout, 4);
        bit_vld = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_word == 16'd0, "R1 reset word", int'(out_word), 0);
        chk(out_vld == 1'b0, "R1 reset strobe", int'(out_vld), 0);
        chk(settled == 1'b0, "R1 reset settled", int'(settled), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 strobe after reset", int'(out_vld), 0);
        for (int d = 0; d <= 16; d++) begin
            for (int s = 0; s <= 4; s++) begin
                run_cfg(s, d, 1'b0);
            end
        end
        run_cfg(0, 5, 1'b1);
        run_cfg(7, 12, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule